// File: doc/BRIEF.md
# Fractionally Trimmed One-Second Prescaler

This block turns a slow crystal clock into a once-per-second strobe. A calibration word sets the length of each second in whole oscillator cycles. An optional fractional trim, in sixteenths of a cycle, is added on top. The trim works by making some seconds one cycle longer. These long seconds are spread evenly over a repeating group of sixteen seconds, so the average second can be tuned much more finely than one oscillator cycle.

Software writes the calibration word through a write strobe and data bus. The stored value is always visible on a separate read-back bus. A new word does not cut the current second short; it applies from the next second boundary. The one-cycle strobe drives a downstream time-of-day counter and an interrupt source.

The calibration word has three fields. Bits 15:0 hold the whole count W. Bits 19:16 hold the fractional count F. Bit 20 is the trim enable E. All bits above bit 20 are dropped.

Top module: `sec_prescaler`

## Requirements
- R1: A synchronous reset loads the calibration word 0x0000_7FFF (W = 0x7FFF, trim disabled) and restarts the second counting. The first second after reset lasts 32768 cycles, and sec_pulse is low while reset is held.
- R2: With the trim disabled, every second lasts exactly W+1 clock cycles.
- R3: When bit 20 is clear, the value in bits 19:16 has no effect on the length of any second.
- R4: With bit 20 set, any 16 consecutive seconds together last exactly 16·(W+1)+F cycles.
- R5: Seconds are numbered from 0 at reset, and the number wraps modulo 16. A second numbered s is one cycle longer exactly when the 4-bit bit-reversal of s is less than F and the trim is enabled.
- R6: A word written during a second does not change the length of that second. It governs every second from the next boundary on.
- R7: cal_rd_data returns bits 20:0 of the last word written and reads zero in bits 31:21. Bits 31:21 of a written word are discarded.
- R8: sec_pulse is high for exactly one clock cycle at the end of each second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_wr_en | input | 1 | Write strobe for the calibration word |
| cal_wr_data | input | 32 | Calibration word to store |
| cal_rd_data | output | 32 | Stored calibration word, upper bits zero |
| sec_pulse | output | 1 | One-cycle strobe at the end of each second |

## Verification
Each second is measured as the number of cycles between strobes, and that count is compared with W+1 plus the extra cycle predicted for that second's number.

The first stimulus is the nominal word after reset, which proves the reset length. The next is a short whole count with the trim off, which separates the base period from any spreading. A word with fraction bits set but the enable clear shows that those bits really have no effect.

Then all sixteen fraction values are applied in turn. For each one, the length of every individual second is checked, which pins down where the long seconds fall. The total over sixteen seconds is also checked, which pins down how many long seconds there are. Writes placed in the middle of a second show that the old length still finishes. A reset in the middle of a run shows that second numbering starts again from 0.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;

   // Placement of the long seconds inside the 16-second group
   typedef enum logic {
      SPREAD_BITREV = 1'b0,   // evenly interleaved (bit-reversed index)
      SPREAD_FRONT  = 1'b1    // clustered at the start of the group
   } spread_e;

endpackage

// File: rtl/sec_cal_store.sv
module sec_cal_store #(
   parameter int WHOLE_W   = 16,
   parameter int FRAC_W    = 4,
   parameter int WORD_W    = 32,
   parameter int NOMINAL   = 32'h7FFF,
   localparam int CAL_BITS = WHOLE_W + FRAC_W + 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [CAL_BITS-1:0] wr_word,
   output logic [CAL_BITS-1:0] cal_q,
   output logic [WORD_W-1:0]   rd_word
);

   localparam logic [CAL_BITS-1:0] RESET_WORD = CAL_BITS'(NOMINAL);

   always_ff @(posedge clk) begin
      if (rst) begin
         cal_q <= RESET_WORD;
      end else if (wr_en) begin
         cal_q <= wr_word;
      end
   end

   assign rd_word = {{(WORD_W-CAL_BITS){1'b0}}, cal_q};

   AST_RESET_NOMINAL: assert property (@(posedge clk)
      rst |=> (rd_word == WORD_W'(NOMINAL)));                        // R1

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      rd_word[WORD_W-1:CAL_BITS] == '0);                               // R7

endmodule

// File: rtl/sec_frac_sched.sv
module sec_frac_sched
   import sec_prescaler_pkg::*;
#(
   parameter int      WHOLE_W = 16,
   parameter int      FRAC_W  = 4,
   parameter int      NOMINAL = 32'h7FFF,
   parameter spread_e SPREAD  = SPREAD_BITREV,
   localparam int     LIM_W   = WHOLE_W + 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               advance,
   input  logic [WHOLE_W-1:0] whole,
   input  logic [FRAC_W-1:0]  frac,
   input  logic               trim_en,
   output logic [LIM_W-1:0]   lim_q
);

   logic [FRAC_W-1:0] idx_q;
   logic [FRAC_W-1:0] idx_nxt;
   logic [FRAC_W-1:0] key;
   logic              extra;

   assign idx_nxt = idx_q + 1'b1;

   generate
      if (SPREAD == SPREAD_BITREV) begin : g_bitrev
         for (genvar b = 0; b < FRAC_W; b++) begin : g_bit
            assign key[b] = idx_nxt[FRAC_W-1-b];
         end
      end else begin : g_front
         assign key = idx_nxt;
      end
   endgenerate

   assign extra = trim_en && (key < frac);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
         lim_q <= LIM_W'(NOMINAL);
      end else if (advance) begin
         idx_q <= idx_nxt;
         lim_q <= {1'b0, whole} + LIM_W'(extra);
      end
   end

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
      advance |=> (idx_q == $past(idx_q) + 1'b1));                     // R5

   AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
      !advance |=> $stable(lim_q));                                    // R6

endmodule

// File: rtl/sec_period_ctr.sv
module sec_period_ctr #(
   parameter int  WHOLE_W = 16,
   localparam int LIM_W   = WHOLE_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LIM_W-1:0] lim,
   output logic             tick
);

   logic [LIM_W-1:0] cnt_q;

   assign tick = (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (rst || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= lim);                                                   // R2

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (tick && lim != '0) |=> !tick);                                  // R8

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
   import sec_prescaler_pkg::*;
#(
   parameter int      WHOLE_W = 16,
   parameter int      FRAC_W  = 4,
   parameter int      WORD_W  = 32,
   parameter int      NOMINAL = 32'h7FFF,
   parameter spread_e SPREAD  = SPREAD_BITREV
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cal_wr_en,
   input  logic [WORD_W-1:0] cal_wr_data,
   output logic [WORD_W-1:0] cal_rd_data,
   output logic              sec_pulse
);

   localparam int FRAC_LSB = WHOLE_W;
   localparam int EN_BIT   = WHOLE_W + FRAC_W;
   localparam int CAL_BITS = EN_BIT + 1;
   localparam int LIM_W    = WHOLE_W + 1;

   generate
      if (CAL_BITS >= WORD_W) begin : g_bad_word
         $error("calibration fields do not fit below WORD_W");
      end
      if (FRAC_W < 1 || WHOLE_W < 2) begin : g_bad_fields
         $error("field widths too small");
      end
      if (NOMINAL >= (1 << WHOLE_W)) begin : g_bad_nominal
         $error("NOMINAL exceeds the whole-count field");
      end
   endgenerate

   logic [CAL_BITS-1:0] cal_q;
   logic [LIM_W-1:0]    lim;
   logic                unused_hi;

   assign unused_hi = ^cal_wr_data[WORD_W-1:CAL_BITS];

   sec_cal_store #(
      .WHOLE_W (WHOLE_W),
      .FRAC_W  (FRAC_W),
      .WORD_W  (WORD_W),
      .NOMINAL (NOMINAL)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cal_wr_en),
      .wr_word (cal_wr_data[CAL_BITS-1:0]),
      .cal_q   (cal_q),
      .rd_word (cal_rd_data)
   );

   sec_frac_sched #(
      .WHOLE_W (WHOLE_W),
      .FRAC_W  (FRAC_W),
      .NOMINAL (NOMINAL),
      .SPREAD  (SPREAD)
   ) u_sched (
      .clk     (clk),
      .rst     (rst),
      .advance (sec_pulse),
      .whole   (cal_q[WHOLE_W-1:0]),
      .frac    (cal_q[EN_BIT-1:FRAC_LSB]),
      .trim_en (cal_q[EN_BIT]),
      .lim_q   (lim)
   );

   sec_period_ctr #(
      .WHOLE_W (WHOLE_W)
   ) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .lim  (lim),
      .tick (sec_pulse)
   );

   AST_NO_PULSE_IN_RESET: assert property (@(posedge clk)
      rst |=> !sec_pulse);                                             // R1

endmodule

// File: tb/sec_prescaler_bench.sv
module sec_prescaler_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cal_wr_en = 1'b0;
   logic [31:0] cal_wr_data = '0;
   logic [31:0] cal_rd_data;
   logic        sec_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // bench model
   bit      mon_on = 0;
   int      cyc = 0;
   int      sum = 0;
   int      ticks = 0;
   int      idx_m = 0;
   logic [31:0] staged_m = 32'h7FFF;
   logic [31:0] active_m = 32'h7FFF;
   string   cur_req = "R1";

   always #10 clk = ~clk;

   sec_prescaler u_sec_prescaler (
      .clk         (clk),
      .rst         (rst),
      .cal_wr_en   (cal_wr_en),
      .cal_wr_data (cal_wr_data),
      .cal_rd_data (cal_rd_data),
      .sec_pulse   (sec_pulse)
   );

   function automatic int rev4(int s);
      return {s[0], s[1], s[2], s[3]};
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (mon_on) begin
         if (sec_pulse) begin
            int w = int'(active_m[15:0]);
            int f = int'(active_m[19:16]);
            int ex = (active_m[20] && rev4(idx_m) < f) ? 1 : 0;
            check(cyc + 1 == w + 1 + ex, cur_req, cyc + 1, w + 1 + ex);
            sum += cyc + 1;
            ticks++;
            idx_m = (idx_m + 1) % 16;
            active_m = staged_m;
            cyc = 0;
         end else begin
            cyc++;
         end
      end
   endtask

   task automatic run_ticks(int n);
      int target = ticks + n;
      while (ticks < target) step();
   endtask

   task automatic wr(logic [31:0] d);
      cal_wr_en   = 1'b1;
      cal_wr_data = d;
      staged_m    = d & 32'h001F_FFFF;
      step();
      cal_wr_en   = 1'b0;
   endtask

   task automatic do_reset();
      mon_on = 0;
      rst = 1'b1;
      repeat (3) step();
      check(cal_rd_data == 32'h7FFF, "R1", cal_rd_data, 32'h7FFF);
      check(sec_pulse == 1'b0, "R1", sec_pulse, 0);
      rst      = 1'b0;
      staged_m = 32'h7FFF;
      active_m = 32'h7FFF;
      idx_m    = 0;
      cyc      = 1;
      mon_on   = 1;
   endtask

   initial begin
      do_reset();
      // R7: upper bits dropped; R6: first second keeps nominal length
      wr(32'hFFE0_0003);
      check(cal_rd_data == 32'h3, "R7", cal_rd_data, 32'h3);
      cur_req = "R1 R6";
      run_ticks(1);
      cur_req = "R2";
      run_ticks(16);
      // R3: fraction bits without enable
      wr(32'h000F_0005);
      check(cal_rd_data == 32'h000F_0005, "R7", cal_rd_data, 32'h000F_0005);
      cur_req = "R3";
      run_ticks(17);
      // R4 R5: sweep all fraction values with W=3
      for (int f = 0; f < 16; f++) begin
         wr(32'h0010_0003 | (32'(f) << 16));
         cur_req = "R6";
         run_ticks(1);
         cur_req = "R5";
         sum = 0;
         run_ticks(16);
         check(sum == 64 + f, "R4", sum, 64 + f);
      end
      // R8: a single pulse per second at the shortest trimmed length
      wr(32'h0010_0001);
      run_ticks(1);
      cur_req = "R8";
      for (int k = 0; k < 8; k++) begin
         step();
         if (sec_pulse) begin
            step();
            check(sec_pulse == 1'b0, "R8", sec_pulse, 0);
         end
      end
      // reset mid-run restarts numbering and the nominal word
      do_reset();
      wr(32'h0011_0002);
      cur_req = "R1";
      run_ticks(1);
      cur_req = "R5";
      sum = 0;
      run_ticks(16);
      check(sum == 16 * 3 + 1, "R4", sum, 49);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule